// File: doc/BRIEF.md
# Coprocessor host port decoder

This block sits between a host CPU and a numeric coprocessor. The CPU talks to the coprocessor through a pair of select lines, a two-bit command code and asynchronous read and write strobes on a 16-bit data bus. The block brings these strobes into the local clock domain through two-flop synchronizers. On the synchronized falling edge of each strobe it fires exactly one event. There are five events: opcode write, operand write, operand read, status read and control read. Each event is a one-cycle strobe with a kind code and the captured write word.

The execution side asks for operand words by pulsing `xfer_start` with a word count. The block then raises `preq` toward the CPU. An acknowledge withdraws the request. Each operand word moved over the bus decrements the count and raises the request again while words remain. `busy` rises when an opcode write is accepted and falls when the execution side pulses `exec_done`. An opcode write that arrives while `busy` is set is dropped and reported on `cmd_err`.

Top module: `copro_host_port`

## Requirements
- R1: An access is decoded only when `sel_a_n` is 0 and `sel_b` is 1. In every other select combination, strobes produce no event, no change in `busy` and no bus drive.
- R2: Command code 3 (`cmd`=11) is ignored for both reads and writes. It produces no event and no bus drive, and it does not set `busy`.
- R3: With a valid select, the events map as follows. A write with `cmd`=00 is an opcode write (kind 1). A write with `cmd`=01 is an operand write (kind 2). A write with `cmd`=10 has no effect. A read with `cmd`=01 is an operand read (kind 3). A read with `cmd`=00 is a status read (kind 4). A read with `cmd`=10 is a control read (kind 5).
- R4: Each strobe fires exactly one `ev_stb` pulse, on its synchronized falling edge. The pulse comes three clock edges after the strobe falls. A strobe held low for many cycles still fires only once.
- R5: For write events, `ev_data` carries the word on `data_in`. For read events, `ev_data` is 0.
- R6: `xfer_start` with a count N (1 to MAX_WORDS) raises `preq` at the next edge. Each operand word (an operand write or operand read event) decrements the count. After a word, `preq` is 1 if words remain and 0 once the count reaches zero.
- R7: A synchronized falling edge of `ack_n` withdraws `preq`. If words remain, the next operand word raises `preq` again. For the last word, `preq` therefore drops at the acknowledge or at the word, whichever comes first.
- R8: An opcode write accepted while `busy` is 0 sets `busy` in the same cycle as its event. A pulse on `exec_done` clears `busy`.
- R9: An opcode write while `busy` is 1 produces no event. It pulses `cmd_err` for one cycle, and `busy` is kept.
- R10: `data_oe` is 1 only while `rd_n` is 0 with a valid select and a code other than 11. `data_out` then shows `status_word` for code 00, `operand_word` for code 01 and `control_word` for code 10.
- R11: After reset, `preq`, `busy`, `ev_stb` and `cmd_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| sel_a_n | input | 1 | Select line, active low |
| sel_b | input | 1 | Select line, active high |
| cmd | input | 2 | Command code |
| rd_n | input | 1 | Asynchronous read strobe, active low |
| wr_n | input | 1 | Asynchronous write strobe, active low |
| data_in | input | DW | Write data from the CPU |
| data_out | output | DW | Read data toward the CPU |
| data_oe | output | 1 | Bus drive enable for data_out |
| status_word | input | DW | Status value returned on code 00 reads |
| control_word | input | DW | Control value returned on code 10 reads |
| operand_word | input | DW | Operand value returned on code 01 reads |
| xfer_start | input | 1 | Starts an operand transfer |
| xfer_len | input | CW | Number of operand words |
| preq | output | 1 | Operand transfer request |
| ack_n | input | 1 | Asynchronous request acknowledge, active low |
| busy | output | 1 | Command in progress |
| exec_done | input | 1 | Execution side finished the command |
| ev_stb | output | 1 | One-cycle event strobe |
| ev_kind | output | 3 | Event kind code |
| ev_data | output | DW | Captured write word |
| cmd_err | output | 1 | Opcode write refused while busy |

## Verification
Accesses are driven with every combination of the two select lines and all four command codes, for both reads and writes. This separates the select gating, the ignored code and the mapping of each event kind. Bus drive and the returned word are checked for each code. Transfers are run three ways: with words only, with an acknowledge before every word, and with a long-held strobe. These runs tell apart the reassert-after-word rule, the early withdrawal on the last word, and the single event per strobe. Opcode writes before and after `exec_done` separate an accepted command from a refused one.

// File: rtl/copro_host_port.sv
module copro_host_port #(
  parameter int DW        = 16,
  parameter int MAX_WORDS = 5,
  localparam int CW       = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic [1:0]    cmd,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  input  logic [DW-1:0] status_word,
  input  logic [DW-1:0] control_word,
  input  logic [DW-1:0] operand_word,
  input  logic          xfer_start,
  input  logic [CW-1:0] xfer_len,
  output logic          preq,
  input  logic          ack_n,
  output logic          busy,
  input  logic          exec_done,
  output logic          ev_stb,
  output logic [2:0]    ev_kind,
  output logic [DW-1:0] ev_data,
  output logic          cmd_err
);
  localparam logic [2:0] K_OPC = 3'd1, K_OPW = 3'd2, K_OPR = 3'd3, K_STR = 3'd4, K_CTR = 3'd5;
  localparam logic [6:0] IDLE = 7'b1011111;

  // {sel_a_n, sel_b, cmd[1:0], rd_n, wr_n, ack_n}
  logic [6:0] s1, s2;
  logic [2:0] s3;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= IDLE;
      s2 <= IDLE;
      s3 <= 3'b111;
    end else begin
      s1 <= {sel_a_n, sel_b, cmd, rd_n, wr_n, ack_n};
      s2 <= s1;
      s3 <= s2[2:0];
    end

  wire hit      = !s2[6] && s2[5] && (s2[4:3] != 2'b11);
  wire rd_fall  = !s2[2] && s3[2];
  wire wr_fall  = !s2[1] && s3[1];
  wire ack_fall = !s2[0] && s3[0];

  wire wr_opc = hit && wr_fall && (s2[4:3] == 2'b00);
  wire wr_opd = hit && wr_fall && (s2[4:3] == 2'b01);
  wire rd_opd = hit && rd_fall && !wr_fall && (s2[4:3] == 2'b01);
  wire rd_st  = hit && rd_fall && !wr_fall && (s2[4:3] == 2'b00);
  wire rd_ct  = hit && rd_fall && !wr_fall && (s2[4:3] == 2'b10);
  wire word   = wr_opd || rd_opd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ev_stb  <= 1'b0;
      ev_kind <= '0;
      ev_data <= '0;
      cmd_err <= 1'b0;
      busy    <= 1'b0;
    end else begin
      ev_stb  <= (wr_opc && !busy) || wr_opd || rd_opd || rd_st || rd_ct;
      ev_kind <= wr_opc ? K_OPC : wr_opd ? K_OPW : rd_opd ? K_OPR : rd_st ? K_STR : rd_ct ? K_CTR : 3'd0;
      ev_data <= (wr_opc || wr_opd) ? data_in : '0;
      cmd_err <= wr_opc && busy;
      if (wr_opc && !busy) busy <= 1'b1;
      else if (exec_done)  busy <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt  <= '0;
      preq <= 1'b0;
    end else if (xfer_start) begin
      cnt  <= xfer_len;
      preq <= (xfer_len != '0);
    end else if (word && cnt != '0) begin
      cnt  <= cnt - 1'b1;
      preq <= (cnt != CW'(1));
    end else if (ack_fall) begin
      preq <= 1'b0;
    end

  assign data_oe = !rd_n && !sel_a_n && sel_b && (cmd != 2'b11);

  always_comb
    case (cmd)
      2'b00:   data_out = status_word;
      2'b01:   data_out = operand_word;
      2'b10:   data_out = control_word;
      default: data_out = '0;
    endcase

  a_r8_busy_with_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (ev_stb && ev_kind == K_OPC));
  a_r9_err_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> ($past(busy) && !ev_stb));
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stb |=> !ev_stb);
  a_r6_req_has_words: assert property (@(posedge clk) disable iff (!rst_n)
    preq |-> (cnt != '0));
  a_r7_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(preq) |-> $past(ack_fall || word));
  a_r1_event_selected: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stb |-> $past(hit));
endmodule

// File: tb/copro_host_port_tb.sv
module copro_host_port_tb_top;
  logic clk = 0, rst_n = 0;
  logic sel_a_n = 1, sel_b = 0, rd_n = 1, wr_n = 1, ack_n = 1;
  logic [1:0] cmd = 2'b11;
  logic [15:0] data_in = 0, data_out;
  logic data_oe, preq, busy, exec_done = 0, ev_stb, cmd_err, xfer_start = 0;
  logic [2:0] xfer_len = 0, ev_kind;
  logic [15:0] ev_data;
  localparam logic [15:0] ST_W = 16'h3A41, CT_W = 16'h037F, OP_W = 16'hBEEF;

  int checks = 0, errors = 0, err_pulses = 0;
  logic [18:0] exp_q[$];
  bit done = 0;

  always #10 clk = ~clk;

  copro_host_port dut_i (.clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .cmd(cmd),
    .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .status_word(ST_W), .control_word(CT_W), .operand_word(OP_W), .xfer_start(xfer_start),
    .xfer_len(xfer_len), .preq(preq), .ack_n(ack_n), .busy(busy), .exec_done(exec_done),
    .ev_stb(ev_stb), .ev_kind(ev_kind), .ev_data(ev_data), .cmd_err(cmd_err));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmd_err) err_pulses++;
    if (rst_n && ev_stb) begin
      if (exp_q.size() == 0) chk(0, "R1/R2/R4 unexpected event", {13'b0, ev_kind, ev_data}, 0);
      else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        chk({ev_kind, ev_data} == e, "R3/R5 event kind and data", {13'b0, ev_kind, ev_data}, {13'b0, e});
      end
    end
  end

  task automatic access(input bit is_rd, input logic a_n, input logic b, input logic [1:0] c,
                        input logic [15:0] d, input logic [2:0] kind, input int hold, input string tag);
    bit oe_exp;
    logic [15:0] v_exp;
    oe_exp = !a_n && b && c != 2'b11;
    v_exp = (c == 2'b00) ? ST_W : (c == 2'b01) ? OP_W : CT_W;
    if (kind != 0) exp_q.push_back({kind, is_rd ? 16'h0 : d});
    @(negedge clk); sel_a_n = a_n; sel_b = b; cmd = c; data_in = d;
    @(negedge clk); if (is_rd) rd_n = 0; else wr_n = 0;
    @(negedge clk);
    if (is_rd) begin
      chk(data_oe == oe_exp, {"R10 drive enable ", tag}, data_oe, oe_exp);
      if (oe_exp) chk(data_out == v_exp, {"R10 read word ", tag}, data_out, v_exp);
    end
    repeat (hold) @(negedge clk);
    rd_n = 1; wr_n = 1;
    @(negedge clk);
    if (is_rd) chk(data_oe == 0, "R10 float after read", data_oe, 0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, {"R4 event count ", tag}, exp_q.size(), 0);
    sel_a_n = 1; sel_b = 0; cmd = 2'b11;
  endtask

  task automatic start_xfer(input logic [2:0] n);
    @(negedge clk); xfer_start = 1; xfer_len = n;
    @(negedge clk); xfer_start = 0;
    chk(preq == 1, "R6 request on start", preq, 1);
  endtask

  task automatic pulse_ack;
    @(negedge clk); ack_n = 0;
    repeat (4) @(negedge clk);
    ack_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(preq == 0 && busy == 0 && ev_stb == 0 && cmd_err == 0, "R11 reset state",
        {preq, busy, ev_stb, cmd_err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(preq == 0 && busy == 0, "R11 after release", {preq, busy}, 0);

    access(0, 0, 1, 2'b00, 16'hD9C0, 3'd1, 2, "opcode");
    chk(busy == 1, "R8 busy set", busy, 1);
    access(0, 0, 1, 2'b00, 16'h1111, 3'd0, 2, "opcode while busy");
    chk(err_pulses == 1, "R9 refusal flagged", err_pulses, 1);
    chk(busy == 1, "R9 busy kept", busy, 1);
    @(negedge clk); exec_done = 1; @(negedge clk); exec_done = 0;
    chk(busy == 0, "R8 busy cleared", busy, 0);

    access(0, 0, 1, 2'b01, 16'h5A5A, 3'd2, 2, "operand write");
    access(0, 0, 1, 2'b10, 16'h7777, 3'd0, 2, "code 10 write");
    access(1, 0, 1, 2'b00, 16'h0, 3'd4, 2, "status read");
    access(1, 0, 1, 2'b10, 16'h0, 3'd5, 2, "control read");
    access(1, 0, 1, 2'b01, 16'h0, 3'd3, 2, "operand read");

    access(0, 1, 1, 2'b00, 16'h2222, 3'd0, 2, "R1 a_n high");
    access(0, 0, 0, 2'b00, 16'h2222, 3'd0, 2, "R1 b low");
    access(1, 1, 0, 2'b00, 16'h0, 3'd0, 2, "R1 read unselected");
    chk(busy == 0, "R1 busy untouched", busy, 0);
    access(0, 0, 1, 2'b11, 16'h3333, 3'd0, 2, "R2 write");
    access(1, 0, 1, 2'b11, 16'h0, 3'd0, 2, "R2 read");
    chk(busy == 0, "R2 busy untouched", busy, 0);
    chk(data_oe == 0, "R10 idle float", data_oe, 0);

    access(0, 0, 1, 2'b01, 16'hCAFE, 3'd2, 25, "R4 long hold");

    start_xfer(3'd3);
    access(0, 0, 1, 2'b01, 16'h0001, 3'd2, 1, "R6 w1");
    chk(preq == 1, "R6 reassert after word 1", preq, 1);
    access(1, 0, 1, 2'b01, 16'h0, 3'd3, 1, "R6 w2");
    chk(preq == 1, "R6 reassert after word 2", preq, 1);
    access(0, 0, 1, 2'b01, 16'h0003, 3'd2, 1, "R6 w3");
    chk(preq == 0, "R6 drop after last word", preq, 0);

    start_xfer(3'd2);
    pulse_ack;
    chk(preq == 0, "R7 ack withdraws", preq, 0);
    access(0, 0, 1, 2'b01, 16'h00A1, 3'd2, 1, "R7 w1");
    chk(preq == 1, "R7 reassert with words left", preq, 1);
    pulse_ack;
    chk(preq == 0, "R7 ack on last word", preq, 0);
    access(0, 0, 1, 2'b01, 16'h00A2, 3'd2, 1, "R7 w2");
    chk(preq == 0, "R7 stays low after last word", preq, 0);

    start_xfer(3'd1);
    access(1, 0, 1, 2'b01, 16'h0, 3'd3, 1, "R6 single");
    chk(preq == 0, "R6 single word drop", preq, 0);

    done = 1;
    finish_run();
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule